// File: doc/BRIEF.md
# Register-Programming Test Access Port

This block is a four-wire serial test port built around the sixteen-state IEEE 1149.1 controller. An external host clocks it with `tck`, steers it with `tms`, feeds serial data on `tdi` and reads serial data from `tdo`. A 6-bit instruction selects one of four serial paths between `tdi` and `tdo`. The paths are a fixed 32-bit identification word, a one-bit pass-through, a short stand-in boundary chain, and a 16-bit programming stage that reaches a bank of internal configuration registers.

An instruction whose top bit is one selects register programming, except the all-ones code. Its low five bits name the target register. On Capture-DR the addressed register is copied in parallel into the programming stage. The host then shifts a new value in while the old value shifts out. On the falling edge of `tck` in Update-DR the new value is written back to the same register. A single scan therefore reads one register and writes it in the same pass.

Under the two boundary instructions, a stand-in chain captures the `pin_in` vector. Its update latches, which drive `pin_out`, load on the falling edge in Update-DR.

Top module: `jtr_tap_top`

## Requirements
- R1: The controller follows the sixteen-state IEEE 1149.1 transition graph on rising `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `rst` high on a rising edge also forces Test-Logic-Reset.
- R2: While the controller is in Test-Logic-Reset, the active instruction is IDCODE, opcode 011111.
- R3: The instruction stage is 6 bits wide and loads the pattern 000001 in Capture-IR. It shifts least-significant bit first toward `tdo`. The active instruction changes only on the falling `tck` edge in Update-IR, or in Test-Logic-Reset.
- R4: IDCODE (011111) loads the 32-bit parameter `IDCODE_VAL` in Capture-DR and shifts it out least-significant bit first. Bits entering on `tdi` never alter the value captured by a later scan.
- R5: BYPASS (111111) selects a one-bit stage that captures 0 in Capture-DR. The output of an n-bit scan is therefore 0 followed by the input delayed by one bit. Any opcode that is neither 000000, 000001, 011111 nor of the form 1SSSSS also selects this stage.
- R6: An opcode 1SSSSS other than 111111 selects register programming at address SSSSS (0 to 30). Capture-DR copies that 16-bit register into the programming stage, and a scan shifts it out least-significant bit first.
- R7: Under register programming, on the falling `tck` edge in Update-DR, the programming stage is written into register SSSSS and no other register changes.
- R8: No register of the bank changes during a scan under IDCODE, BYPASS, EXTEST or SAMPLE/PRELOAD.
- R9: EXTEST (000000) and SAMPLE/PRELOAD (000001) select a `CHAIN_W`-cell chain. Cell i captures `pin_in[i]` in Capture-DR, and cell 0 lies nearest `tdo`.
- R10: `pin_out` is 0 after reset. It changes only on the falling `tck` edge in Update-DR under EXTEST or SAMPLE/PRELOAD, when it takes the shifted chain contents.
- R11: `tdo` changes on falling `tck` edges and is 0 whenever the controller is in neither Shift-DR nor Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; controller and shift stages on rising edge, updates and `tdo` on falling edge |
| rst | input | 1 | Synchronous active-high reset to Test-Logic-Reset |
| tms | input | 1 | Mode select sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` in shift states |
| pin_in | input | CHAIN_W | Values captured by the stand-in boundary chain |
| tdo | output | 1 | Serial data out, registered on falling `tck` |
| pin_out | output | CHAIN_W | Boundary update latches |

## Verification
The controller enters Shift-DR or Shift-IR on a rising edge. The first serial bit then appears on `tdo` at the following falling edge, and the host consumes it on the next rising edge. The bench therefore reads `tdo` 1 ns after each falling edge and changes `tms`/`tdi` 1 ns after each rising edge. Register writes and `pin_out` take effect on the falling edge that follows the rising edge entering Update-DR. The bench checks `pin_out` in Exit1-DR and again in Update-DR to show it has not yet moved. It then checks once more after the edge that leaves Update-DR, where the new value must be present. Writes are checked by a later capture through the port itself.

// File: rtl/jtr_pkg.sv
package jtr_pkg;

  localparam int IR_W = 6;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS, PATH_IDENT, PATH_REGS, PATH_CHAIN
  } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'b011111;
  localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;
  localparam logic [IR_W-1:0] IR_CAP_PAT = 6'b000001;

  function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
    dr_path_e p;
    if (op == OP_EXTEST || op == OP_SAMPLE) p = PATH_CHAIN;
    else if (op == OP_IDCODE)               p = PATH_IDENT;
    else if (op == OP_BYPASS)               p = PATH_BYPASS;
    else if (op[IR_W-1])                    p = PATH_REGS;
    else                                    p = PATH_BYPASS;
    return p;
  endfunction

endpackage

// File: rtl/jtr_tap_fsm.sv
module jtr_tap_fsm
  import jtr_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/jtr_regbank.sv
module jtr_regbank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              tck,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Write on the falling test-clock edge, as the update phase requires.
  always_ff @(negedge tck) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/jtr_chain.sv
module jtr_chain #(
  parameter int CELLS = 8
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             shf_en,
  input  logic             upd_en,
  input  logic             tdi,
  input  logic [CELLS-1:0] pin_in,
  output logic             so,
  output logic [CELLS-1:0] pin_out
);

  logic [CELLS-1:0] stage_q;
  logic [CELLS-1:0] latch_q;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic link_in;
    if (i == CELLS - 1) begin : g_head
      assign link_in = tdi;
    end else begin : g_body
      assign link_in = stage_q[i+1];
    end

    always_ff @(posedge tck) begin
      if (rst)         stage_q[i] <= 1'b0;
      else if (cap_en) stage_q[i] <= pin_in[i];
      else if (shf_en) stage_q[i] <= link_in;
    end

    always_ff @(negedge tck) begin
      if (rst)         latch_q[i] <= 1'b0;
      else if (upd_en) latch_q[i] <= stage_q[i];
    end
  end

  assign so      = stage_q[0];
  assign pin_out = latch_q;

endmodule

// File: rtl/jtr_tap_top.sv
module jtr_tap_top
  import jtr_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          CHAIN_W    = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h2C5E_A0D3
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] pin_in,
  output logic               tdo,
  output logic [CHAIN_W-1:0] pin_out
);

  localparam int ADDR_W = IR_W - 1;
  localparam int ID_W   = 32;

  tap_state_e        state;
  logic [IR_W-1:0]   ir_shift;
  logic [IR_W-1:0]   ir_active;
  dr_path_e          path;
  logic [ID_W-1:0]   id_shift;
  logic              byp_q;
  logic [DATA_W-1:0] reg_shift;
  logic [DATA_W-1:0] rd_data;
  logic              chain_so;
  logic              dr_lsb;
  logic              tdo_q;

  jtr_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  // Instruction shift stage (rising edge)
  always_ff @(posedge tck) begin
    if (rst)                    ir_shift <= IR_CAP_PAT;
    else if (state == ST_CAP_IR) ir_shift <= IR_CAP_PAT;
    else if (state == ST_SHF_IR) ir_shift <= {tdi, ir_shift[IR_W-1:1]};
  end

  // Active instruction (falling edge)
  always_ff @(negedge tck) begin
    if (rst || state == ST_RESET) ir_active <= OP_IDCODE;
    else if (state == ST_UPD_IR)  ir_active <= ir_shift;
  end

  assign path = decode_path(ir_active);

  wire cap_dr = (state == ST_CAP_DR);
  wire shf_dr = (state == ST_SHF_DR);

  // Identification stage; the stored constant itself is never touched.
  always_ff @(posedge tck) begin
    if (rst)                            id_shift <= IDCODE_VAL;
    else if (path == PATH_IDENT && cap_dr) id_shift <= IDCODE_VAL;
    else if (path == PATH_IDENT && shf_dr) id_shift <= {tdi, id_shift[ID_W-1:1]};
  end

  // One-bit pass-through
  always_ff @(posedge tck) begin
    if (rst)                              byp_q <= 1'b0;
    else if (path == PATH_BYPASS && cap_dr) byp_q <= 1'b0;
    else if (path == PATH_BYPASS && shf_dr) byp_q <= tdi;
  end

  // Register programming stage
  always_ff @(posedge tck) begin
    if (rst)                             reg_shift <= '0;
    else if (path == PATH_REGS && cap_dr) reg_shift <= rd_data;
    else if (path == PATH_REGS && shf_dr) reg_shift <= {tdi, reg_shift[DATA_W-1:1]};
  end

  jtr_regbank #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .tck     (tck),
    .wr_en   (!rst && path == PATH_REGS && state == ST_UPD_DR),
    .addr    (ir_active[ADDR_W-1:0]),
    .wr_data (reg_shift),
    .rd_data (rd_data)
  );

  jtr_chain #(
    .CELLS (CHAIN_W)
  ) u_chain (
    .tck     (tck),
    .rst     (rst),
    .cap_en  (path == PATH_CHAIN && cap_dr),
    .shf_en  (path == PATH_CHAIN && shf_dr),
    .upd_en  (path == PATH_CHAIN && state == ST_UPD_DR),
    .tdi     (tdi),
    .pin_in  (pin_in),
    .so      (chain_so),
    .pin_out (pin_out)
  );

  always_comb begin
    case (path)
      PATH_IDENT: dr_lsb = id_shift[0];
      PATH_REGS:  dr_lsb = reg_shift[0];
      PATH_CHAIN: dr_lsb = chain_so;
      default:    dr_lsb = byp_q;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) tdo_q <= 1'b0;
    else begin
      case (state)
        ST_SHF_IR: tdo_q <= ir_shift[0];
        ST_SHF_DR: tdo_q <= dr_lsb;
        default:   tdo_q <= 1'b0;
      endcase
    end
  end

  assign tdo = tdo_q;

endmodule

// File: rtl/jtr_tap_chk.sv
module jtr_tap_chk
  import jtr_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          CHAIN_W    = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h2C5E_A0D3
) (
  input logic               tck,
  input logic               rst,
  input logic               tms,
  input logic               tdo,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_shift,
  input logic [IR_W-1:0]    ir_active,
  input dr_path_e           path,
  input logic [31:0]        id_shift,
  input logic               byp_q,
  input logic [DATA_W-1:0]  reg_shift,
  input logic [DATA_W-1:0]  rd_data,
  input logic [CHAIN_W-1:0] pin_out
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck) begin
    if (rst)          hi_cnt <= '0;
    else if (!tms)    hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  assert_tlr_after_five_R1: assert property (@(posedge tck) disable iff (rst)
    hi_cnt >= 3'd5 |-> state == ST_RESET);

  assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (rst)
    state == ST_RESET |-> ir_active == OP_IDCODE);

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (rst)
    state == ST_CAP_IR |=> ir_shift == IR_CAP_PAT);

  assert_ir_hold_R3: assert property (@(posedge tck) disable iff (rst)
    ir_active != $past(ir_active) |-> (state == ST_UPD_IR || state == ST_RESET));

  assert_id_capture_R4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && path == PATH_IDENT) |=> id_shift == IDCODE_VAL);

  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && path == PATH_BYPASS) |=> byp_q == 1'b0);

  assert_reg_capture_R6: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && path == PATH_REGS) |=> reg_shift == $past(rd_data));

  assert_pin_hold_R10: assert property (@(posedge tck) disable iff (rst)
    pin_out != $past(pin_out) |-> (state == ST_UPD_DR && path == PATH_CHAIN));

  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (rst)
    !(state == ST_SHF_DR || state == ST_SHF_IR) |-> tdo == 1'b0);

endmodule

bind jtr_tap_top jtr_tap_chk #(
  .DATA_W     (DATA_W),
  .CHAIN_W    (CHAIN_W),
  .IDCODE_VAL (IDCODE_VAL)
) u_chk (
  .tck       (tck),
  .rst       (rst),
  .tms       (tms),
  .tdo       (tdo),
  .state     (state),
  .ir_shift  (ir_shift),
  .ir_active (ir_active),
  .path      (path),
  .id_shift  (id_shift),
  .byp_q     (byp_q),
  .reg_shift (reg_shift),
  .rd_data   (rd_data),
  .pin_out   (pin_out)
);

// File: tb/jtr_tap_top_tb.sv
module jtr_tap_top_tb;

  localparam int          DATA_W  = 16;
  localparam int          CHAIN_W = 8;
  localparam logic [31:0] ID      = 32'h2C5E_A0D3;

  logic               tck = 1'b0;
  logic               rst = 1'b1;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [CHAIN_W-1:0] pin_in = '0;
  logic               tdo;
  logic [CHAIN_W-1:0] pin_out;

  int checks = 0;
  int errors = 0;

  always #4 tck = ~tck;

  jtr_tap_top #(
    .DATA_W     (DATA_W),
    .CHAIN_W    (CHAIN_W),
    .IDCODE_VAL (ID)
  ) u_dut (
    .tck     (tck),
    .rst     (rst),
    .tms     (tms),
    .tdi     (tdi),
    .pin_in  (pin_in),
    .tdo     (tdo),
    .pin_out (pin_out)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change 1 ns after a rising edge; tdo is read 1 ns after the falling edge.
  task automatic step(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    @(negedge tck);
    #1;
    o = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic to_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 6; i++) begin
      step(i == 5, op[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_dr_exit(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    scan_dr_exit(n, din, dout);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic t_reset();
    logic o;
    rst = 1'b1;
    repeat (4) @(posedge tck);
    #1;
    rst = 1'b0;
    check("R11 tdo after reset", {63'd0, tdo}, 64'd0);
    check("R10 pin_out after reset", {56'd0, pin_out}, 64'd0);
    step(1'b0, 1'b0, o);
    check("R11 tdo in idle", {63'd0, o}, 64'd0);
  endtask

  task automatic t_idcode();
    logic [63:0] d;
    scan_dr(32, 64'hFFFF_FFFF, d);
    check("R2 idcode active after reset", d, {32'd0, ID});
    scan_dr(32, 64'h0F0F_0000, d);
    check("R4 idcode unchanged by tdi", d, {32'd0, ID});
  endtask

  task automatic t_ir_capture();
    logic [5:0] c;
    scan_ir(6'b011111, c);
    check("R3 capture-ir pattern", {58'd0, c}, 64'd1);
    check("R11 tdo quiet after ir scan", {63'd0, tdo}, 64'd0);
  endtask

  task automatic t_regprog();
    logic [5:0]  c;
    logic [63:0] d;
    scan_ir(6'b100101, c);
    scan_dr(16, 64'hA5C3, d);
    scan_ir(6'b100110, c);
    scan_dr(16, 64'h0F1E, d);
    scan_ir(6'b111110, c);
    scan_dr(16, 64'h1234, d);
    scan_ir(6'b100000, c);
    scan_dr(16, 64'hFFFF, d);
    scan_ir(6'b100101, c);
    scan_dr(16, 64'h5A5A, d);
    check("R6 read reg5", d, 64'hA5C3);
    scan_dr(16, 64'h5A5A, d);
    check("R7 rewrite reg5", d, 64'h5A5A);
    scan_ir(6'b100110, c);
    scan_dr(16, 64'h0F1E, d);
    check("R7 reg6 untouched by reg5 write", d, 64'h0F1E);
    scan_ir(6'b111110, c);
    scan_dr(16, 64'h1234, d);
    check("R6 read reg30", d, 64'h1234);
    scan_ir(6'b100000, c);
    scan_dr(16, 64'hFFFF, d);
    check("R6 read reg0", d, 64'hFFFF);
  endtask

  task automatic t_bypass();
    logic [5:0]  c;
    logic [63:0] d;
    scan_ir(6'b111111, c);
    scan_dr(8, 64'hB7, d);
    check("R5 bypass delay", d, 64'h6E);
    scan_ir(6'b010101, c);
    scan_dr(8, 64'h81, d);
    check("R5 undefined opcode bypass", d, 64'h02);
    scan_ir(6'b011111, c);
    scan_dr(32, 64'h0, d);
    scan_ir(6'b100101, c);
    scan_dr(16, 64'h5A5A, d);
    check("R8 reg5 kept through other scans", d, 64'h5A5A);
  endtask

  task automatic t_chain();
    logic [5:0]  c;
    logic [63:0] d;
    logic        o;
    pin_in = 8'h96;
    scan_ir(6'b000000, c);
    scan_dr_exit(8, 64'h3C, d);
    check("R9 extest capture", d, 64'h96);
    check("R10 pin_out held in exit1", {56'd0, pin_out}, 64'd0);
    step(1'b1, 1'b0, o);
    check("R10 pin_out held entering update", {56'd0, pin_out}, 64'd0);
    step(1'b0, 1'b0, o);
    check("R10 pin_out after update", {56'd0, pin_out}, 64'h3C);
    pin_in = 8'h5A;
    scan_ir(6'b000001, c);
    scan_dr(8, 64'hC3, d);
    check("R9 sample capture", d, 64'h5A);
    check("R10 pin_out after preload", {56'd0, pin_out}, 64'hC3);
    scan_ir(6'b100101, c);
    scan_dr(16, 64'h5A5A, d);
    check("R10 pin_out kept under reg programming", {56'd0, pin_out}, 64'hC3);
    check("R8 reg5 kept through chain scans", d, 64'h5A5A);
  endtask

  task automatic t_tms_reset();
    logic [5:0]  c;
    logic [63:0] d;
    logic        o;
    scan_ir(6'b111111, c);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, o);
    step(1'b0, 1'b0, o);
    scan_dr(32, 64'h0, d);
    check("R1 five tms high resets, R2 idcode selected", d, {32'd0, ID});
  endtask

  initial begin
    t_reset();
    t_idcode();
    t_ir_capture();
    t_regprog();
    t_bypass();
    t_chain();
    t_tms_reset();
    to_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule